// File: doc/BRIEF.md
# Debug-State Cache Policy Controller

This block sits beside a level-one instruction and data cache pair and decides, for every access, whether a miss may allocate a line and where a write must go while the core is halted for debugging. It holds a small control register with three override bits. Both the core and an external debug port can read it and write it. Outside debug state the overrides have no effect, and the caches follow the allocation and write policy of each region.

While halted, the debugger can keep the caches exactly as the halted program left them, so that read misses are fetched from memory without allocating. It can also push every data write through to memory, so that code or breakpoints it writes are seen by the instruction side once the matching lines are invalidated. Read hits are not affected. The block also filters cache-maintenance and system-control requests. A core in secure user mode with secure privileged debug disabled may only issue requests marked as user-accessible. The only exceptions are two instruction-side operations, which are always allowed in debug state.

Top module: `dbg_cache_policy`

## Requirements
- R1: After reset the control register holds zero, and both read ports return zero. Bits above bit 2 always read as zero.
- R2: A debug-port write is visible on both read ports in the next cycle. When the core writes in the same cycle, the debug-port value is the one kept.
- R3: The core is restricted when `sec_user` is high and `spd_en` is low. A core write while restricted is dropped, and `core_err` goes high for exactly the following cycle. An accepted core write is visible next cycle, and `core_err` stays low.
- R4: With `halted` high and control bit 0 set, `ic_linefill` stays low on an instruction read miss. Otherwise `ic_linefill` equals `ic_rd_miss`.
- R5: With `halted` high and control bit 1 set, `dc_linefill` stays low on a data read miss. Otherwise `dc_linefill` equals `dc_rd_miss`.
- R6: With `halted` high and control bit 2 set, every valid data write raises `dc_wr_mem`, and a write hit also raises `dc_wr_upd`.
- R7: With `halted` high and control bit 1 set, a write miss raises `dc_wr_mem` and leaves `dc_wr_fill` and `dc_wr_upd` low, whatever the value of bit 2.
- R8: With `halted` low, writes follow the region policy. A hit sets `dc_wr_upd`, and sets `dc_wr_mem` only when `dc_attr_wb` is low. A miss allocates (`dc_wr_fill` and `dc_wr_upd`) when `dc_attr_walloc` is high. It sets `dc_wr_mem` unless it both allocates and is write-back. With no valid write, all three write outputs are low.
- R9: A maintenance request is rejected when restricted, `mnt_user_ok` is low, and the request is not whitelisted. The cycle after a rejected request, `mnt_err` is high and `mnt_grant` is low. The cycle after an accepted request, `mnt_grant` is high and `mnt_err` is low. With no request, both are low.
- R10: Operation codes 1 (instruction-cache invalidate by range) and 2 (branch-target cache flush) are whitelisted only while `halted` is high. Outside debug state they obey the R9 restriction like any other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halted | input | 1 | Core is in debug state |
| sec_user | input | 1 | Core is in secure user mode |
| spd_en | input | 1 | Secure privileged debug enable |
| core_wr_en | input | 1 | Core write to the control register |
| core_wr_data | input | 32 | Core write data |
| core_rd_data | output | 32 | Control register as seen by the core |
| core_err | output | 1 | One-cycle pulse for a rejected core write |
| dap_wr_en | input | 1 | Debug-port write to the control register |
| dap_wr_data | input | 32 | Debug-port write data |
| dap_rd_data | output | 32 | Control register as seen by the debug port |
| mnt_req | input | 1 | Maintenance or system-control request |
| mnt_op | input | 4 | Operation code of the request |
| mnt_user_ok | input | 1 | Request is one that user mode may access |
| mnt_grant | output | 1 | Request accepted (one cycle after request) |
| mnt_err | output | 1 | Request rejected (one cycle after request) |
| ic_rd_miss | input | 1 | Instruction read miss this cycle |
| ic_linefill | output | 1 | Allow instruction linefill for the miss |
| dc_rd_miss | input | 1 | Data read miss this cycle |
| dc_linefill | output | 1 | Allow data linefill for the miss |
| dc_wr_valid | input | 1 | Data write this cycle |
| dc_wr_hit | input | 1 | The write hits in the data cache |
| dc_attr_wb | input | 1 | Region is write-back (low: write-through) |
| dc_attr_walloc | input | 1 | Region allocates on write miss |
| dc_wr_upd | output | 1 | Write updates the cache |
| dc_wr_mem | output | 1 | Write goes to memory |
| dc_wr_fill | output | 1 | Write miss allocates a line |

## Verification
The bench targets four corner cases.

- **Both ports write in the same cycle.** A design that gave the core priority would keep the wrong value.
- **Core write while restricted.** A design that dropped the register guard would change the register and stay silent on `core_err`.
- **Write miss with data fill blocked and write-through forced.** A design that let the write-through bit win would allocate a line, breaking the promise that the cache is left untouched.
- **Whitelisted operations when restricted, inside and outside debug state.** A design that ignored `halted` in the whitelist would grant them outside debug state, and one that lacked the whitelist would reject them while halted.

Random traffic over all input combinations, outside and inside debug state, covers the remaining policy truth table.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
   localparam int unsigned BIT_IC_NOFILL = 0;
   localparam int unsigned BIT_DC_NOFILL = 1;
   localparam int unsigned BIT_FORCE_WT  = 2;
   localparam int unsigned IMPL_BITS     = 3;

   typedef struct packed {
      logic force_wt;
      logic dc_nofill;
      logic ic_nofill;
   } dcp_ctrl_t;
endpackage

// File: rtl/dcp_ctrl_reg.sv
module dcp_ctrl_reg
   import dcp_pkg::*;
#(
   parameter int unsigned CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restricted,
   input  logic              core_wr_en,
   input  logic [CTRL_W-1:0] core_wr_data,
   input  logic              dap_wr_en,
   input  logic [CTRL_W-1:0] dap_wr_data,
   output dcp_ctrl_t         ctrl,
   output logic [CTRL_W-1:0] rd_data,
   output logic              core_err
);
   localparam int unsigned PAD_W = CTRL_W - IMPL_BITS;

   dcp_ctrl_t nxt;
   logic      core_ok;

   assign core_ok = core_wr_en & ~restricted;

   always_comb begin
      nxt = ctrl;
      if (dap_wr_en)
         nxt = dcp_ctrl_t'(dap_wr_data[IMPL_BITS-1:0]);
      else if (core_ok)
         nxt = dcp_ctrl_t'(core_wr_data[IMPL_BITS-1:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         core_err <= 1'b0;
      end else begin
         ctrl     <= nxt;
         core_err <= core_wr_en & restricted;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         logic unused_hi;
         assign unused_hi = ^{core_wr_data[CTRL_W-1:IMPL_BITS], dap_wr_data[CTRL_W-1:IMPL_BITS]};
         assign rd_data   = {{PAD_W{1'b0}}, ctrl};
      end else begin : g_nopad
         assign rd_data = ctrl;
      end
   endgenerate

   p_dap_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dap_wr_en |=> ctrl == $past(dap_wr_data[IMPL_BITS-1:0]));
   p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_wr_en && restricted && !dap_wr_en) |=> $stable(ctrl));
   p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      core_err |-> $past(core_wr_en && restricted));
endmodule

// File: rtl/dcp_perm.sv
module dcp_perm #(
   parameter int unsigned OP_W   = 4,
   parameter logic [OP_W-1:0] OP_IC_RANGE = 1,
   parameter logic [OP_W-1:0] OP_BTC_FLUSH = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halted,
   input  logic            restricted,
   input  logic            mnt_req,
   input  logic [OP_W-1:0] mnt_op,
   input  logic            mnt_user_ok,
   output logic            mnt_grant,
   output logic            mnt_err
);
   logic listed, allowed;

   assign listed  = halted & ((mnt_op == OP_IC_RANGE) | (mnt_op == OP_BTC_FLUSH));
   assign allowed = ~restricted | mnt_user_ok | listed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mnt_grant <= 1'b0;
         mnt_err   <= 1'b0;
      end else begin
         mnt_grant <= mnt_req & allowed;
         mnt_err   <= mnt_req & ~allowed;
      end
   end

   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mnt_grant && mnt_err));
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mnt_req |=> !mnt_grant && !mnt_err);
   p_listed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mnt_req && halted && (mnt_op == OP_IC_RANGE || mnt_op == OP_BTC_FLUSH)) |=> mnt_grant);
endmodule

// File: rtl/dcp_policy.sv
module dcp_policy
   import dcp_pkg::*;
#(
   parameter bit POLICY_REG = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      halted,
   input  dcp_ctrl_t ctrl,
   input  logic      ic_rd_miss,
   input  logic      dc_rd_miss,
   input  logic      dc_wr_valid,
   input  logic      dc_wr_hit,
   input  logic      dc_attr_wb,
   input  logic      dc_attr_walloc,
   output logic      ic_linefill,
   output logic      dc_linefill,
   output logic      dc_wr_upd,
   output logic      dc_wr_mem,
   output logic      dc_wr_fill
);
   logic ic_blk, dc_blk, wt_all;
   logic c_ic_lf, c_dc_lf, c_upd, c_mem, c_fill, miss;

   assign ic_blk = halted & ctrl.ic_nofill;
   assign dc_blk = halted & ctrl.dc_nofill;
   assign wt_all = halted & ctrl.force_wt;
   assign miss   = dc_wr_valid & ~dc_wr_hit;

   assign c_ic_lf = ic_rd_miss & ~ic_blk;
   assign c_dc_lf = dc_rd_miss & ~dc_blk;
   assign c_fill  = miss & dc_attr_walloc & ~dc_blk;
   assign c_upd   = (dc_wr_valid & dc_wr_hit) | c_fill;
   assign c_mem   = dc_wr_valid & (wt_all | ~dc_attr_wb | (miss & ~c_fill));

   generate
      if (POLICY_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               {ic_linefill, dc_linefill, dc_wr_upd, dc_wr_mem, dc_wr_fill} <= '0;
            end else begin
               {ic_linefill, dc_linefill, dc_wr_upd, dc_wr_mem, dc_wr_fill} <=
                  {c_ic_lf, c_dc_lf, c_upd, c_mem, c_fill};
            end
         end
      end else begin : g_comb
         assign {ic_linefill, dc_linefill, dc_wr_upd, dc_wr_mem, dc_wr_fill} =
            {c_ic_lf, c_dc_lf, c_upd, c_mem, c_fill};

         p_miss_noalloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (halted && ctrl.dc_nofill && dc_wr_valid && !dc_wr_hit) |-> dc_wr_mem && !dc_wr_fill && !dc_wr_upd);
         p_wt_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (halted && ctrl.force_wt && dc_wr_valid) |-> dc_wr_mem);
         p_normal_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!halted && (ic_rd_miss || dc_rd_miss)) |-> (ic_linefill == ic_rd_miss) && (dc_linefill == dc_rd_miss));
      end
   endgenerate
endmodule

// File: rtl/dbg_cache_policy.sv
module dbg_cache_policy
   import dcp_pkg::*;
#(
   parameter int unsigned CTRL_W = 32,
   parameter int unsigned OP_W   = 4,
   parameter logic [OP_W-1:0] OP_IC_RANGE = 1,
   parameter logic [OP_W-1:0] OP_BTC_FLUSH = 2,
   parameter bit POLICY_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halted,
   input  logic              sec_user,
   input  logic              spd_en,
   input  logic              core_wr_en,
   input  logic [CTRL_W-1:0] core_wr_data,
   output logic [CTRL_W-1:0] core_rd_data,
   output logic              core_err,
   input  logic              dap_wr_en,
   input  logic [CTRL_W-1:0] dap_wr_data,
   output logic [CTRL_W-1:0] dap_rd_data,
   input  logic              mnt_req,
   input  logic [OP_W-1:0]   mnt_op,
   input  logic              mnt_user_ok,
   output logic              mnt_grant,
   output logic              mnt_err,
   input  logic              ic_rd_miss,
   output logic              ic_linefill,
   input  logic              dc_rd_miss,
   output logic              dc_linefill,
   input  logic              dc_wr_valid,
   input  logic              dc_wr_hit,
   input  logic              dc_attr_wb,
   input  logic              dc_attr_walloc,
   output logic              dc_wr_upd,
   output logic              dc_wr_mem,
   output logic              dc_wr_fill
);
   generate
      if (CTRL_W < IMPL_BITS) begin : g_bad_width
         $error("CTRL_W must hold the implemented control bits");
      end
      if (OP_IC_RANGE == OP_BTC_FLUSH) begin : g_bad_ops
         $error("whitelisted operation codes must differ");
      end
   endgenerate

   logic        restricted;
   dcp_ctrl_t   ctrl;
   logic [CTRL_W-1:0] rd_data;

   assign restricted   = sec_user & ~spd_en;
   assign core_rd_data = rd_data;
   assign dap_rd_data  = rd_data;

   dcp_ctrl_reg #(.CTRL_W(CTRL_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .restricted(restricted),
      .core_wr_en(core_wr_en), .core_wr_data(core_wr_data),
      .dap_wr_en(dap_wr_en), .dap_wr_data(dap_wr_data),
      .ctrl(ctrl), .rd_data(rd_data), .core_err(core_err)
   );

   dcp_perm #(.OP_W(OP_W), .OP_IC_RANGE(OP_IC_RANGE), .OP_BTC_FLUSH(OP_BTC_FLUSH)) u_perm (
      .clk(clk), .rst_n(rst_n), .halted(halted), .restricted(restricted),
      .mnt_req(mnt_req), .mnt_op(mnt_op), .mnt_user_ok(mnt_user_ok),
      .mnt_grant(mnt_grant), .mnt_err(mnt_err)
   );

   dcp_policy #(.POLICY_REG(POLICY_REG)) u_pol (
      .clk(clk), .rst_n(rst_n), .halted(halted), .ctrl(ctrl),
      .ic_rd_miss(ic_rd_miss), .dc_rd_miss(dc_rd_miss),
      .dc_wr_valid(dc_wr_valid), .dc_wr_hit(dc_wr_hit),
      .dc_attr_wb(dc_attr_wb), .dc_attr_walloc(dc_attr_walloc),
      .ic_linefill(ic_linefill), .dc_linefill(dc_linefill),
      .dc_wr_upd(dc_wr_upd), .dc_wr_mem(dc_wr_mem), .dc_wr_fill(dc_wr_fill)
   );

   p_rd_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rd_data >> IMPL_BITS) == '0);
endmodule

// File: tb/dbg_cache_policy_test.sv
`timescale 1ns/1ps
module dbg_cache_policy_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        halted = 0, sec_user = 0, spd_en = 0;
   logic        core_wr_en = 0, dap_wr_en = 0;
   logic [31:0] core_wr_data = 0, dap_wr_data = 0;
   logic [31:0] core_rd_data, dap_rd_data;
   logic        core_err;
   logic        mnt_req = 0, mnt_user_ok = 0;
   logic [3:0]  mnt_op = 0;
   logic        mnt_grant, mnt_err;
   logic        ic_rd_miss = 0, dc_rd_miss = 0, dc_wr_valid = 0, dc_wr_hit = 0;
   logic        dc_attr_wb = 0, dc_attr_walloc = 0;
   logic        ic_linefill, dc_linefill, dc_wr_upd, dc_wr_mem, dc_wr_fill;

   int          n_chk = 0, n_fail = 0;
   logic [2:0]  mreg = 3'b000;

   always #2.5 clk = ~clk;

   dbg_cache_policy uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // {ic_linefill, dc_linefill, upd, mem, fill}
   function automatic logic [4:0] exp_pol(input logic h, input logic [2:0] c,
         input logic icm, input logic dcm, input logic wv, input logic wh,
         input logic wb, input logic wa);
      logic ib, db, wt, lf_i, lf_d, upd, mem, fill;
      ib = h & c[0]; db = h & c[1]; wt = h & c[2];
      lf_i = icm & ~ib; lf_d = dcm & ~db;
      upd = 0; mem = 0; fill = 0;
      if (wv) begin
         if (wh) begin
            upd = 1; mem = wt | ~wb;
         end else begin
            fill = wa & ~db; upd = fill; mem = wt | ~wb | ~fill;
         end
      end
      return {lf_i, lf_d, upd, mem, fill};
   endfunction

   function automatic logic exp_allow(input logic h, input logic su, input logic sp,
         input logic uok, input logic [3:0] op);
      return ~(su & ~sp) | uok | (h & (op == 4'd1 || op == 4'd2));
   endfunction

   // drive at negedge, check comb outputs, then registered outputs after the edge
   task automatic step;
      logic [4:0] ep;
      logic [2:0] nreg;
      logic       restr, ok, eerr;
      #1;
      ep = exp_pol(halted, mreg, ic_rd_miss, dc_rd_miss, dc_wr_valid, dc_wr_hit, dc_attr_wb, dc_attr_walloc);
      chk("R4 ic_linefill", {31'b0, ic_linefill}, {31'b0, ep[4]});
      chk("R5 dc_linefill", {31'b0, dc_linefill}, {31'b0, ep[3]});
      if (!halted) chk("R8 write policy", {29'b0, dc_wr_upd, dc_wr_mem, dc_wr_fill}, {29'b0, ep[2:0]});
      else if (mreg[1] && dc_wr_valid && !dc_wr_hit)
         chk("R7 miss no alloc", {29'b0, dc_wr_upd, dc_wr_mem, dc_wr_fill}, {29'b0, ep[2:0]});
      else chk("R6 debug write", {29'b0, dc_wr_upd, dc_wr_mem, dc_wr_fill}, {29'b0, ep[2:0]});
      restr = sec_user & ~spd_en;
      eerr  = core_wr_en & restr;
      nreg  = dap_wr_en ? dap_wr_data[2:0] : (core_wr_en && !restr) ? core_wr_data[2:0] : mreg;
      ok    = exp_allow(halted, sec_user, spd_en, mnt_user_ok, mnt_op);
      @(posedge clk); #1;
      mreg = nreg;
      chk("R2 dap read", dap_rd_data, {29'b0, mreg});
      chk("R3 core read", core_rd_data, {29'b0, mreg});
      chk("R3 core_err", {31'b0, core_err}, {31'b0, eerr});
      chk(mnt_op inside {4'd1, 4'd2} ? "R10 grant" : "R9 grant", {31'b0, mnt_grant}, {31'b0, mnt_req & ok});
      chk("R9 err", {31'b0, mnt_err}, {31'b0, mnt_req & ~ok});
      @(negedge clk);
   endtask

   task automatic idle;
      {core_wr_en, dap_wr_en, mnt_req, ic_rd_miss, dc_rd_miss, dc_wr_valid} = '0;
   endtask

   initial begin
      #100000;
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #0.5;
      chk("R1 reset core", core_rd_data, 32'd0);
      chk("R1 reset dap", dap_rd_data, 32'd0);
      @(negedge clk);

      // R2: simultaneous writes, debugger wins; upper bits dropped (R1)
      idle; core_wr_en = 1; core_wr_data = 32'h0000_0005; dap_wr_en = 1; dap_wr_data = 32'hFFFF_FFFA;
      step;
      // R3: restricted core write rejected
      idle; sec_user = 1; spd_en = 0; core_wr_en = 1; core_wr_data = 32'h7;
      step;
      idle; step; // err pulse must drop
      // R7: fill blocked and force wt, halted write miss
      idle; sec_user = 0; dap_wr_en = 1; dap_wr_data = 32'h6; step;
      idle; halted = 1; dc_wr_valid = 1; dc_wr_hit = 0; dc_attr_wb = 1; dc_attr_walloc = 1; step;
      // R10: whitelisted ops restricted, halted and not halted
      for (int k = 1; k <= 2; k++) begin
         idle; sec_user = 1; spd_en = 0; mnt_user_ok = 0; mnt_op = 4'(k);
         halted = 1; mnt_req = 1; step;
         idle; halted = 0; mnt_req = 1; step;
      end

      for (int i = 0; i < 600; i++) begin
         halted         = ($urandom % 2) == 0;
         sec_user       = ($urandom % 2) == 0;
         spd_en         = ($urandom % 2) == 0;
         core_wr_en     = ($urandom % 10) < 3;
         core_wr_data   = $urandom;
         dap_wr_en      = ($urandom % 10) < 2;
         dap_wr_data    = $urandom;
         mnt_req        = ($urandom % 10) < 6;
         mnt_op         = 4'($urandom % 5);
         mnt_user_ok    = ($urandom % 10) < 3;
         ic_rd_miss     = $urandom;
         dc_rd_miss     = $urandom;
         dc_wr_valid    = $urandom;
         dc_wr_hit      = $urandom;
         dc_attr_wb     = $urandom;
         dc_attr_walloc = $urandom;
         step;
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule